// File: doc/BRIEF.md
# Byte Transfer and Index Arithmetic Unit

This unit carries out the byte-wide and address-wide operations of a nibble-oriented processor core. It holds a byte register made of two nibbles (the low nibble is called the A half, the high nibble the B half), two 16-bit index registers, each with a low byte and a high byte, a byte-wide page register, two byte-wide stack pointers, and a carry flag and a zero flag. The core hands it one 13-bit instruction word at a time with `insn_valid`. Most words finish at the next clock edge. Transfers between the byte register and memory move one nibble per cycle over a nibble-wide memory port and take two cycles.

Memory reads are asynchronous: the data for `mem_addr` must be on `mem_rdata` in the same cycle. Memory writes happen on the clock edge that ends a cycle in which `mem_we` is high. While `busy` is high the unit ignores `insn_valid`, and the core is expected to hold its next instruction. Instruction words outside the groups listed below change nothing.

Top module: `pair_index_unit`

## Requirements
- R1: A synchronous reset clears all registers (byte register, both indexes, page, both stack pointers, carry, zero) and `busy`. With `insn_valid` low, `mem_we` and `mem_re` are low.
- R2: A word whose top five bits are a load prefix places its low byte in a target register, one cycle after it is accepted. Prefix 01001 loads the byte register (bits 7:4 go to the B half), 01000 loads the page register, 01010 loads the low byte of index 0, and 01011 loads the low byte of index 1. Loading a low byte leaves that index's high byte unchanged.
- R3: A word with bits 12:6 all ones belongs to the register group, selected by bits 5:0. Sub-code 0x00+k copies location k into the byte register, and 0x08+k copies the byte register into location k. The locations are k=0 index 0 low, 1 index 0 high, 2 index 1 low, 3 index 1 high, 4 page, 5 stack pointer 0, 6 stack pointer 1.
- R4: Sub-code 0x10 (index 0) or 0x11 (index 1) loads the byte register from memory over two cycles. `busy` is high in the second cycle. The A half is read from the index address. The B half is read from the same high byte with the low byte plus 1, wrapping within 8 bits. The index low byte then grows by 2 modulo 256, and the high byte is kept.
- R5: Sub-code 0x12 (index 0) or 0x13 (index 1) stores the byte register over two cycles. The A half goes to the index address, the B half goes to the next address (formed as in R4), and the index is then updated as in R4. `mem_we` and `mem_re` are never high together.
- R6: Prefix 00001 stores its byte operand through index 0 over two cycles. Operand bits 3:0 go first to the index address and bits 7:4 to the next address, and index 0 is then updated as in R4.
- R7: Prefix 01100 (index 0) or 01101 (index 1) adds the operand byte, sign-extended to 16 bits, to the whole index (range -128 to 127). The carry can reach the high byte.
- R8: Sub-code 0x14 (index 0) or 0x15 (index 1) adds the byte register, taken as unsigned, to the index low byte modulo 256. The high byte is unchanged.
- R9: Prefix 01110 (index 0) or 01111 (index 1) compares the index low byte against an immediate whose ones' complement is held in bits 7:0. Carry is set when the immediate is greater than the low byte, and zero is set when they are equal. No register other than the flags changes.
- R10: Sub-codes 0x18 and 0x19 increment stack pointer 0 and 1, and 0x1A and 0x1B decrement them. Both directions wrap modulo 256.
- R11: A word offered while `busy` is high is ignored. A word outside the groups above (including sub-code 0x07 and sub-code 0x3F) changes no register.
- R12: Only a compare (R9) changes the carry and zero flags. Moves, loads, stores, additions and stack steps leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is offered this cycle |
| insn | input | 13 | Instruction word |
| busy | output | 1 | Second cycle of a memory transfer; new words are ignored |
| mem_addr | output | 16 | Nibble memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 4 | Write nibble |
| mem_rdata | input | 4 | Read nibble for the current address (asynchronous) |
| pair_out | output | 8 | Byte register, B half in bits 7:4 |
| idx0_out | output | 16 | Index register 0 |
| idx1_out | output | 16 | Index register 1 |
| page_out | output | 8 | Page register |
| stk0_out | output | 8 | Stack pointer 0 |
| stk1_out | output | 8 | Stack pointer 1 |
| carry_out | output | 1 | Carry / borrow flag |
| zero_out | output | 1 | Zero / equal flag |

## Verification
The bench builds the unit with its default nibble width of 4. This gives 8-bit bytes and 16-bit indexes, so each wrap boundary can be reached with a single immediate: a low byte of 0xFF or 0xFE before a post-increment, a negative offset that borrows out of the high byte, and a stack pointer stepping below zero. The memory model decodes the low 10 address bits, which is enough for an index high byte of 0x01. With that index, the post-increment and second-nibble wrap can be checked at 0x1FF followed by 0x100. Compare results cover the equal case, the borrow case, and an immediate of zero.

// File: rtl/piu_pkg.sv
package piu_pkg;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_MOV_TO_PAIR,
    OP_MOV_FROM_PAIR,
    OP_IMM_PAIR,
    OP_IMM_PAGE,
    OP_IMM_IDXLO,
    OP_ADD_SIGNED,
    OP_ADD_PAIR,
    OP_CMP,
    OP_LOAD,
    OP_STORE,
    OP_STORE_IMM,
    OP_SP_INC,
    OP_SP_DEC
  } xop_e;

  // location code k of the register group (sub-codes 0x00+k / 0x08+k)
  typedef enum logic [2:0] {
    LOC_XLO  = 3'd0,
    LOC_XHI  = 3'd1,
    LOC_YLO  = 3'd2,
    LOC_YHI  = 3'd3,
    LOC_PAGE = 3'd4,
    LOC_STK0 = 3'd5,
    LOC_STK1 = 3'd6,
    LOC_NONE = 3'd7
  } loc_e;

  typedef struct packed {
    xop_e op;
    logic sel_y;     // index 1 instead of index 0
    loc_e loc;
    logic sel_stk1;  // stack pointer 1 instead of 0
  } xdec_t;

  localparam logic [4:0] PFX_IMM_PAIR  = 5'b01001;
  localparam logic [4:0] PFX_IMM_PAGE  = 5'b01000;
  localparam logic [4:0] PFX_IMM_XLO   = 5'b01010;
  localparam logic [4:0] PFX_IMM_YLO   = 5'b01011;
  localparam logic [4:0] PFX_ADD_X     = 5'b01100;
  localparam logic [4:0] PFX_ADD_Y     = 5'b01101;
  localparam logic [4:0] PFX_CMP_X     = 5'b01110;
  localparam logic [4:0] PFX_CMP_Y     = 5'b01111;
  localparam logic [4:0] PFX_STORE_IMM = 5'b00001;

endpackage

// File: rtl/piu_decode.sv
module piu_decode
  import piu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [2*NIB_W+4:0] insn,
  output xdec_t              dec,
  output logic [2*NIB_W-1:0] imm
);
  localparam int BYTE_W = 2 * NIB_W;
  localparam int INSN_W = BYTE_W + 5;
  localparam int GRP_W  = INSN_W - 6;

  logic [4:0] prefix;
  logic [5:0] sub;

  always_comb begin
    prefix = insn[INSN_W-1 -: 5];
    sub    = insn[5:0];
    imm    = insn[BYTE_W-1:0];
    dec    = '{op: OP_NOP, sel_y: 1'b0, loc: LOC_NONE, sel_stk1: 1'b0};
    if (&insn[INSN_W-1 -: GRP_W]) begin
      case (sub[5:3])
        3'b000: if (sub[2:0] != 3'd7) begin
          dec.op  = OP_MOV_TO_PAIR;
          dec.loc = loc_e'(sub[2:0]);
        end
        3'b001: if (sub[2:0] != 3'd7) begin
          dec.op  = OP_MOV_FROM_PAIR;
          dec.loc = loc_e'(sub[2:0]);
        end
        3'b010: begin
          if (!sub[2]) begin
            dec.op    = sub[1] ? OP_STORE : OP_LOAD;
            dec.sel_y = sub[0];
          end else if (!sub[1]) begin
            dec.op    = OP_ADD_PAIR;
            dec.sel_y = sub[0];
          end
        end
        3'b011: if (!sub[2]) begin
          dec.op       = sub[1] ? OP_SP_DEC : OP_SP_INC;
          dec.sel_stk1 = sub[0];
        end
        default: ;
      endcase
    end else begin
      case (prefix)
        PFX_IMM_PAIR:  dec.op = OP_IMM_PAIR;
        PFX_IMM_PAGE:  dec.op = OP_IMM_PAGE;
        PFX_IMM_XLO:   dec.op = OP_IMM_IDXLO;
        PFX_IMM_YLO:   begin dec.op = OP_IMM_IDXLO; dec.sel_y = 1'b1; end
        PFX_ADD_X:     dec.op = OP_ADD_SIGNED;
        PFX_ADD_Y:     begin dec.op = OP_ADD_SIGNED; dec.sel_y = 1'b1; end
        PFX_CMP_X:     dec.op = OP_CMP;
        PFX_CMP_Y:     begin dec.op = OP_CMP; dec.sel_y = 1'b1; end
        PFX_STORE_IMM: dec.op = OP_STORE_IMM;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/piu_index.sv
module piu_index #(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [2*NIB_W-1:0]   wdata,
  input  logic                 lo_add_en,
  input  logic [2*NIB_W-1:0]   lo_add_val,
  input  logic                 full_add_en,
  input  logic [4*NIB_W-1:0]   full_add_val,
  output logic [4*NIB_W-1:0]   q
);
  localparam int BYTE_W = 2 * NIB_W;
  localparam int ADDR_W = 2 * BYTE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (full_add_en) begin
      q <= q + full_add_val;
    end else begin
      if (lo_add_en)  q[BYTE_W-1:0] <= q[BYTE_W-1:0] + lo_add_val;
      else if (wr_lo) q[BYTE_W-1:0] <= wdata;
      if (wr_hi)      q[ADDR_W-1:BYTE_W] <= wdata;
    end
  end

  AST_LO_ADD_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (lo_add_en && !wr_hi && !full_add_en) |=> q[ADDR_W-1:BYTE_W] == $past(q[ADDR_W-1:BYTE_W])); // R8
  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!lo_add_en && !wr_lo && !wr_hi && !full_add_en) |=> $stable(q)); // R11
endmodule

// File: rtl/piu_memseq.sv
module piu_memseq #(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 is_store,
  input  logic                 is_imm,
  input  logic                 use_y,
  input  logic [2*NIB_W-1:0]   pair,
  input  logic [2*NIB_W-1:0]   imm,
  input  logic [4*NIB_W-1:0]   idx0,
  input  logic [4*NIB_W-1:0]   idx1,
  input  logic [NIB_W-1:0]     rdata,
  output logic                 busy,
  output logic [4*NIB_W-1:0]   addr,
  output logic                 we,
  output logic                 re,
  output logic [NIB_W-1:0]     wdata,
  output logic                 nib_wr_lo,
  output logic                 nib_wr_hi,
  output logic [NIB_W-1:0]     nib_data,
  output logic                 bump,
  output logic                 bump_y
);
  localparam int BYTE_W = 2 * NIB_W;
  localparam int ADDR_W = 2 * BYTE_W;

  logic             busy_q, y_q, st_q;
  logic [NIB_W-1:0] hi_q;
  logic             cur_y, cur_st, active, go;
  logic [ADDR_W-1:0] base;

  assign go = start && !busy_q;

  always_comb begin
    cur_y   = busy_q ? y_q : use_y;
    cur_st  = busy_q ? st_q : is_store;
    base    = cur_y ? idx1 : idx0;
    active  = busy_q || start;
    addr    = busy_q ? {base[ADDR_W-1:BYTE_W], base[BYTE_W-1:0] + BYTE_W'(1)} : base;
    we      = active && cur_st;
    re      = active && !cur_st;
    wdata   = busy_q ? hi_q : (is_imm ? imm[NIB_W-1:0] : pair[NIB_W-1:0]);
    nib_wr_lo = go && !is_store;
    nib_wr_hi = busy_q && !st_q;
    nib_data  = rdata;
    bump    = busy_q;
    bump_y  = y_q;
    busy    = busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      y_q    <= 1'b0;
      st_q   <= 1'b0;
      hi_q   <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      y_q    <= use_y;
      st_q   <= is_store;
      hi_q   <= is_imm ? imm[BYTE_W-1:NIB_W] : pair[BYTE_W-1:NIB_W];
    end else begin
      busy_q <= 1'b0;
    end
  end

  AST_TWO_PHASE: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q); // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> $past(start)); // R4
  AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (addr[BYTE_W-1:0] == BYTE_W'($past(addr[BYTE_W-1:0]) + BYTE_W'(1))
                && addr[ADDR_W-1:BYTE_W] == $past(addr[ADDR_W-1:BYTE_W]))); // R4
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(we && re)); // R5
endmodule

// File: rtl/pair_index_unit.sv
module pair_index_unit
  import piu_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 insn_valid,
  input  logic [2*NIB_W+4:0]   insn,
  output logic                 busy,
  output logic [4*NIB_W-1:0]   mem_addr,
  output logic                 mem_we,
  output logic                 mem_re,
  output logic [NIB_W-1:0]     mem_wdata,
  input  logic [NIB_W-1:0]     mem_rdata,
  output logic [2*NIB_W-1:0]   pair_out,
  output logic [4*NIB_W-1:0]   idx0_out,
  output logic [4*NIB_W-1:0]   idx1_out,
  output logic [2*NIB_W-1:0]   page_out,
  output logic [2*NIB_W-1:0]   stk0_out,
  output logic [2*NIB_W-1:0]   stk1_out,
  output logic                 carry_out,
  output logic                 zero_out
);
  localparam int BYTE_W = 2 * NIB_W;
  localparam int ADDR_W = 2 * BYTE_W;

  xdec_t             dec;
  logic [BYTE_W-1:0] imm;
  logic              fire, mem_start;
  logic [BYTE_W-1:0] pair_q, page_q, src;
  logic              carry_q, zero_q;
  logic [ADDR_W-1:0] idx0_w, idx1_w;
  logic [BYTE_W-1:0] stk0_w, stk1_w;
  logic              nib_wr_lo, nib_wr_hi, bump, bump_y;
  logic [NIB_W-1:0]  nib_data;
  logic [BYTE_W-1:0] cmp_lo, cmp_imm;

  piu_decode #(.NIB_W(NIB_W)) u_dec (.insn(insn), .dec(dec), .imm(imm));

  assign fire      = insn_valid && !busy;
  assign mem_start = fire && (dec.op == OP_LOAD || dec.op == OP_STORE || dec.op == OP_STORE_IMM);

  piu_memseq #(.NIB_W(NIB_W)) u_seq (
    .clk(clk), .rst(rst), .start(mem_start),
    .is_store(dec.op != OP_LOAD), .is_imm(dec.op == OP_STORE_IMM), .use_y(dec.sel_y),
    .pair(pair_q), .imm(imm), .idx0(idx0_w), .idx1(idx1_w), .rdata(mem_rdata),
    .busy(busy), .addr(mem_addr), .we(mem_we), .re(mem_re), .wdata(mem_wdata),
    .nib_wr_lo(nib_wr_lo), .nib_wr_hi(nib_wr_hi), .nib_data(nib_data),
    .bump(bump), .bump_y(bump_y)
  );

  // two index registers, one instance each
  for (genvar g = 0; g < 2; g++) begin : g_idx
    localparam loc_e LO_LOC = g ? LOC_YLO : LOC_XLO;
    localparam loc_e HI_LOC = g ? LOC_YHI : LOC_XHI;
    logic              mine, wr_lo, wr_hi, lo_add_en, full_add_en;
    logic [ADDR_W-1:0] q;
    assign mine        = (dec.sel_y == 1'(g));
    assign wr_lo       = fire && ((dec.op == OP_MOV_FROM_PAIR && dec.loc == LO_LOC) ||
                                  (dec.op == OP_IMM_IDXLO && mine));
    assign wr_hi       = fire && dec.op == OP_MOV_FROM_PAIR && dec.loc == HI_LOC;
    assign lo_add_en   = (bump && bump_y == 1'(g)) || (fire && dec.op == OP_ADD_PAIR && mine);
    assign full_add_en = fire && dec.op == OP_ADD_SIGNED && mine;
    piu_index #(.NIB_W(NIB_W)) u_idx (
      .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wdata(dec.op == OP_IMM_IDXLO ? imm : pair_q),
      .lo_add_en(lo_add_en), .lo_add_val(bump ? BYTE_W'(2) : pair_q),
      .full_add_en(full_add_en), .full_add_val({{BYTE_W{imm[BYTE_W-1]}}, imm}),
      .q(q)
    );
  end

  // two stack pointers
  for (genvar g = 0; g < 2; g++) begin : g_stk
    localparam loc_e MY_LOC = g ? LOC_STK1 : LOC_STK0;
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (fire) begin
        if (dec.op == OP_MOV_FROM_PAIR && dec.loc == MY_LOC)         q <= pair_q;
        else if (dec.op == OP_SP_INC && dec.sel_stk1 == 1'(g))        q <= q + BYTE_W'(1);
        else if (dec.op == OP_SP_DEC && dec.sel_stk1 == 1'(g))        q <= q - BYTE_W'(1);
      end
    end
  end

  assign idx0_w = g_idx[0].q;
  assign idx1_w = g_idx[1].q;
  assign stk0_w = g_stk[0].q;
  assign stk1_w = g_stk[1].q;

  always_comb begin
    case (dec.loc)
      LOC_XLO:  src = idx0_w[BYTE_W-1:0];
      LOC_XHI:  src = idx0_w[ADDR_W-1:BYTE_W];
      LOC_YLO:  src = idx1_w[BYTE_W-1:0];
      LOC_YHI:  src = idx1_w[ADDR_W-1:BYTE_W];
      LOC_PAGE: src = page_q;
      LOC_STK0: src = stk0_w;
      LOC_STK1: src = stk1_w;
      default:  src = '0;
    endcase
  end

  assign cmp_lo  = dec.sel_y ? idx1_w[BYTE_W-1:0] : idx0_w[BYTE_W-1:0];
  assign cmp_imm = ~imm;

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q  <= '0;
      page_q  <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (fire) begin
        case (dec.op)
          OP_IMM_PAIR:    pair_q <= imm;
          OP_MOV_TO_PAIR: pair_q <= src;
          OP_IMM_PAGE:    page_q <= imm;
          OP_MOV_FROM_PAIR: if (dec.loc == LOC_PAGE) page_q <= pair_q;
          OP_CMP: begin
            carry_q <= (cmp_imm > cmp_lo);
            zero_q  <= (cmp_imm == cmp_lo);
          end
          default: ;
        endcase
      end
      if (nib_wr_lo) pair_q[NIB_W-1:0]      <= nib_data;
      if (nib_wr_hi) pair_q[BYTE_W-1:NIB_W] <= nib_data;
    end
  end

  assign pair_out  = pair_q;
  assign idx0_out  = idx0_w;
  assign idx1_out  = idx1_w;
  assign page_out  = page_q;
  assign stk0_out  = stk0_w;
  assign stk1_out  = stk1_w;
  assign carry_out = carry_q;
  assign zero_out  = zero_q;

  AST_FLAGS_ONLY_CMP: assert property (@(posedge clk) disable iff (rst)
    !(fire && dec.op == OP_CMP) |=> (carry_q == $past(carry_q) && zero_q == $past(zero_q))); // R12
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(carry_q && zero_q)); // R9
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> (page_q == $past(page_q) && stk0_w == $past(stk0_w) && stk1_w == $past(stk1_w))); // R11
endmodule

// File: tb/pair_index_unit_tb.sv
`timescale 1ns/1ps
module pair_index_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        insn_valid;
  logic [12:0] insn;
  logic        busy;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [3:0]  mem_wdata, mem_rdata;
  logic [7:0]  pair_out, page_out, stk0_out, stk1_out;
  logic [15:0] idx0_out, idx1_out;
  logic        carry_out, zero_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pair_index_unit u_dut (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn), .busy(busy),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pair_out(pair_out), .idx0_out(idx0_out), .idx1_out(idx1_out),
    .page_out(page_out), .stk0_out(stk0_out), .stk1_out(stk1_out),
    .carry_out(carry_out), .zero_out(zero_out)
  );

  logic [3:0] mem [1024];
  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  // {insn, observe select, expected, requirement}
  // select: 0 byte reg, 1 index 0, 2 index 1, 3 page, 4 stack 0, 5 stack 1, 6 {carry,zero}
  localparam int NV = 30;
  localparam logic [35:0] VEC [NV] = '{
    {5'b01001, 8'h5A, 3'd0, 16'h005A, 4'd2},  // R2 byte reg immediate
    {7'h7F, 6'h0C,    3'd3, 16'h005A, 4'd3},  // R3 page <- byte reg
    {7'h7F, 6'h0D,    3'd4, 16'h005A, 4'd3},  // R3 stack 0 <- byte reg
    {5'b01000, 8'h01, 3'd3, 16'h0001, 4'd2},  // R2 page immediate
    {7'h7F, 6'h04,    3'd0, 16'h0001, 4'd3},  // R3 byte reg <- page
    {7'h7F, 6'h09,    3'd1, 16'h0100, 4'd3},  // R3 index 0 high <- byte reg
    {5'b01010, 8'hFE, 3'd1, 16'h01FE, 4'd2},  // R2 index 0 low immediate
    {5'b01001, 8'hC3, 3'd0, 16'h00C3, 4'd2},  // R2
    {7'h7F, 6'h12,    3'd1, 16'h0100, 4'd5},  // R5 store, low byte FE+2 wraps
    {5'b00001, 8'h7E, 3'd1, 16'h0102, 4'd6},  // R6 immediate store
    {5'b01010, 8'hFF, 3'd1, 16'h01FF, 4'd2},  // R2
    {7'h7F, 6'h10,    3'd0, 16'h00EC, 4'd4},  // R4 load: A from 1FF, B from 100
    {13'h0000,        3'd1, 16'h0101, 4'd4},  // R4 index after load, word is a no-op
    {5'b01100, 8'h80, 3'd1, 16'h0081, 4'd7},  // R7 add -128 borrows from high byte
    {5'b01100, 8'h7F, 3'd1, 16'h0100, 4'd7},  // R7 add +127 carries into high byte
    {5'b01101, 8'hFF, 3'd2, 16'hFFFF, 4'd7},  // R7 index 1 add -1
    {7'h7F, 6'h15,    3'd2, 16'hFFEB, 4'd8},  // R8 index 1 += EC, low byte wraps
    {5'b01111, 8'h14, 3'd6, 16'h0001, 4'd9},  // R9 equal (imm EB)
    {5'b01111, 8'h0F, 3'd6, 16'h0002, 4'd9},  // R9 borrow (imm F0)
    {7'h7F, 6'h03,    3'd6, 16'h0002, 4'd12}, // R12 move keeps flags
    {7'h7F, 6'h02,    3'd0, 16'h00EB, 4'd3},  // R3 byte reg <- index 1 low
    {5'b01110, 8'hFF, 3'd6, 16'h0001, 4'd9},  // R9 imm 00 equals low byte 00
    {5'b01110, 8'hFE, 3'd6, 16'h0002, 4'd9},  // R9 imm 01 > 00
    {13'h0000,        3'd1, 16'h0100, 4'd9},  // R9 compare left index 0 alone
    {7'h7F, 6'h1A,    3'd4, 16'h0059, 4'd10}, // R10 stack 0 decrement
    {7'h7F, 6'h1B,    3'd5, 16'h00FF, 4'd10}, // R10 stack 1 wraps below zero
    {7'h7F, 6'h19,    3'd5, 16'h0000, 4'd10}, // R10 stack 1 wraps above FF
    {7'h7F, 6'h0E,    3'd5, 16'h00EB, 4'd3},  // R3 stack 1 <- byte reg
    {7'h7F, 6'h07,    3'd0, 16'h00EB, 4'd11}, // R11 unused sub-code
    {7'h7F, 6'h3F,    3'd4, 16'h0059, 4'd11}  // R11 unused sub-code
  };

  task automatic check(input string what, input int req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] observe(input logic [2:0] sel);
    case (sel)
      3'd0: return {8'h00, pair_out};
      3'd1: return idx0_out;
      3'd2: return idx1_out;
      3'd3: return {8'h00, page_out};
      3'd4: return {8'h00, stk0_out};
      3'd5: return {8'h00, stk1_out};
      default: return {14'd0, carry_out, zero_out};
    endcase
  endfunction

  task automatic exec(input logic [12:0] w);
    @(negedge clk);
    insn_valid = 1'b1;
    insn = w;
    @(negedge clk);
    insn_valid = 1'b0;
    insn = '0;
    if (busy) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    check({tag, " byte reg"}, 1, {8'h00, pair_out}, 16'h0000);  // R1
    check({tag, " index 0"}, 1, idx0_out, 16'h0000);
    check({tag, " index 1"}, 1, idx1_out, 16'h0000);
    check({tag, " page/stacks"}, 1, {page_out | stk0_out | stk1_out, 8'h00}, 16'h0000);
    check({tag, " flags/busy/strobes"}, 1,
          {11'd0, carry_out, zero_out, busy, mem_we, mem_re}, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 4'h0;
    rst = 1'b1;
    insn_valid = 1'b0;
    insn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("reset");  // R1

    for (int i = 0; i < NV; i++) begin
      exec(VEC[i][35:23]);
      check($sformatf("vector %0d", i), int'(VEC[i][3:0]), observe(VEC[i][22:20]), VEC[i][19:4]);
    end

    // R5 / R6 memory contents, A half (or bits 3:0) at the lower address
    check("store A half at 1FE", 5, {12'd0, mem[10'h1FE]}, 16'h0003);
    check("store B half at 1FF", 5, {12'd0, mem[10'h1FF]}, 16'h000C);
    check("imm store low nibble at 100", 6, {12'd0, mem[10'h100]}, 16'h000E);
    check("imm store high nibble at 101", 6, {12'd0, mem[10'h101]}, 16'h0007);

    // R4 / R11: load through index 0 (0100) while a new word is offered during busy
    @(negedge clk);
    insn_valid = 1'b1;
    insn = {7'h7F, 6'h10};
    @(negedge clk);
    check("busy in second cycle", 4, {15'd0, busy}, 16'h0001);
    insn = {5'b01001, 8'h11};
    @(negedge clk);
    insn_valid = 1'b0;
    insn = '0;
    check("busy drops after two cycles", 4, {15'd0, busy}, 16'h0000);
    check("word during busy ignored", 11, {8'h00, pair_out}, 16'h007E);
    check("index after second load", 4, idx0_out, 16'h0102);

    // R1 reset again from a loaded state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state("re-reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule